// File: doc/BRIEF.md
# Encoded Output Divider with Auxiliary Clock Select

This block sits behind a high-rate oscillator and turns it into two clocks for the rest of the chip. The primary clock is the oscillator clock divided by one of eight integer ratios between 2 and 10. A 3-bit code picks the ratio, and the code-to-ratio map is deliberately out of order. Odd ratios have a 50% duty cycle, like even ones: a flop on the falling edge stretches the high phase by half an oscillator cycle.

The auxiliary clock comes from a four-way selector driven by a 2-bit function code. It can carry the reference clock unchanged, the reference divided by two, a constant low, or the primary clock divided by two. A single active-high run input powers the block down. When run is low, both output enables drop at once. After a short synchronizer delay, all divider state is parked with its outputs low. When run returns, the divider restarts with a full first period. A new ratio code is taken only at the boundary between two primary periods, so changing the code never produces a runt pulse.

Top module: `outdiv_top`

## Requirements
- R1: The primary period is N oscillator cycles, where N is set by the ratio code. The map is: code 3'b000 gives N=10, 3'b001 gives 2, 3'b010 gives 8, 3'b011 gives 4, 3'b100 gives 5, 3'b101 gives 7, 3'b110 gives 3 and 3'b111 gives 6.
- R2: The primary output is high for exactly N half-cycles of the oscillator out of 2N, for both even and odd N. Every period starts with a rising edge on an oscillator rising edge.
- R3: A ratio code change takes effect only when the current primary period ends. The period in progress completes with the old ratio and no shorter period appears.
- R4: Function code 2'b00 passes the reference clock to the auxiliary output.
- R5: Function code 2'b01 gives the reference clock divided by two, toggling on every rising reference edge.
- R6: Function code 2'b10 holds the auxiliary output low.
- R7: Function code 2'b11 gives the primary clock divided by two, toggling at each rising primary edge.
- R8: Power-down behaves as follows:
  - When run is low, both output enables are low immediately.
  - After synchronization, the primary clock and both divide-by-two sources are held low.
  - When run returns high, the first primary period is a full period.
- R9: While reset is asserted, the primary clock and both divide-by-two sources are low.
- R10: Changing the auxiliary function code does not alter the primary period or duty cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Oscillator-rate clock that is divided to form the primary output |
| ref_clk | input | 1 | Reference clock, a source for the auxiliary output |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| run | input | 1 | High to operate; low tri-states both outputs and parks the dividers |
| div_code | input | 3 | Primary ratio code (map in R1) |
| aux_fn | input | 2 | Auxiliary source select (R4 to R7) |
| pri_clk | output | 1 | Primary divided clock |
| pri_oe | output | 1 | Output enable for pri_clk |
| aux_clk | output | 1 | Auxiliary clock |
| aux_oe | output | 1 | Output enable for aux_clk |

## Verification
The bench walks the divider through all eight ratio codes in turn. Each period is measured in half-cycles, so an odd ratio with a falling-edge extension can be told apart from one that is one cycle short or long. Every code step is made just after a rising primary edge. This separates a design that swaps the ratio at the period boundary from one that swaps it mid-period. The bench also toggles the auxiliary function code during a long odd-ratio run, which shows the auxiliary selector is independent of the primary divider. Power-down in the middle of a period shows whether the restart period is full or truncated.

// File: rtl/odsel_pkg.sv
package odsel_pkg;
  localparam int MAX_DIV = 10;
  localparam int DW      = $clog2(MAX_DIV + 1);

  typedef logic [DW-1:0] ratio_t;

  typedef enum logic [1:0] {
    AUX_REF      = 2'b00,
    AUX_REF_HALF = 2'b01,
    AUX_LOW      = 2'b10,
    AUX_PRI_HALF = 2'b11
  } aux_fn_e;

  function automatic ratio_t code_to_ratio(input logic [2:0] code);
    ratio_t r;
    unique case (code)
      3'b000: r = ratio_t'(10);
      3'b001: r = ratio_t'(2);
      3'b010: r = ratio_t'(8);
      3'b011: r = ratio_t'(4);
      3'b100: r = ratio_t'(5);
      3'b101: r = ratio_t'(7);
      3'b110: r = ratio_t'(3);
      default: r = ratio_t'(6);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/lvl_sync.sv
module lvl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/half_tog.sv
module half_tog (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic adv,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (hold) q <= 1'b0;
    else if (adv)  q <= ~q;
  end
endmodule

// File: rtl/pdiv_core.sv
module pdiv_core
  import odsel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic [2:0] code,
  output logic       clk_out,
  output logic       wrap,
  output ratio_t     ratio
);
  ratio_t cnt, cnt_nx, n_nx, n_code;
  logic   hi_q, odd_q, ext_q;

  // Last cycle of the current period: the only point a new ratio is taken.
  assign wrap   = (cnt == ratio - 1'b1);
  assign n_code = code_to_ratio(code);

  always_comb begin
    n_nx   = wrap ? n_code : ratio;
    cnt_nx = wrap ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio <= ratio_t'(2);
      cnt   <= ratio_t'(1);
      hi_q  <= 1'b0;
      odd_q <= 1'b0;
    end else if (!active) begin
      // Parked one step before a wrap, so the first active edge opens a full period.
      ratio <= n_code;
      cnt   <= n_code - 1'b1;
      hi_q  <= 1'b0;
      odd_q <= 1'b0;
    end else begin
      ratio <= n_nx;
      cnt   <= cnt_nx;
      hi_q  <= (cnt_nx < (n_nx >> 1));
      odd_q <= n_nx[0];
    end
  end

  // Half-cycle stretch of the high phase for odd ratios.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= hi_q & odd_q;
  end

  assign clk_out = hi_q | ext_q;
endmodule

// File: rtl/outdiv_chk.sv
module outdiv_chk
  import odsel_pkg::*;
(
  input logic   vco_clk,
  input logic   rst_n,
  input logic   run_v,
  input logic   core_wrap,
  input ratio_t core_ratio,
  input logic   pri_clk,
  input logic   pri_half
);
  a_r1_ratio_legal: assert property (@(posedge vco_clk) disable iff (!rst_n)
    core_ratio >= ratio_t'(2) && core_ratio <= ratio_t'(10) && core_ratio != ratio_t'(9));

  a_r3_ratio_held_midperiod: assert property (@(posedge vco_clk) disable iff (!rst_n)
    run_v && !core_wrap |=> $stable(core_ratio));

  a_r2_rise_after_wrap: assert property (@(posedge vco_clk) disable iff (!rst_n)
    run_v && core_wrap |=> pri_clk);

  a_r8_idle_low: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !run_v |=> !pri_clk && !pri_half);

  a_r7_half_toggles: assert property (@(posedge vco_clk) disable iff (!rst_n)
    run_v && core_wrap |=> pri_half != $past(pri_half));

  a_r7_half_steady: assert property (@(posedge vco_clk) disable iff (!rst_n)
    run_v && !core_wrap |=> $stable(pri_half));
endmodule

bind outdiv_top outdiv_chk i_chk (
  .vco_clk   (vco_clk),
  .rst_n     (rst_n),
  .run_v     (run_v),
  .core_wrap (core_wrap),
  .core_ratio(core_ratio),
  .pri_clk   (pri_clk),
  .pri_half  (pri_half)
);

// File: rtl/outdiv_top.sv
module outdiv_top
  import odsel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       vco_clk,
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] div_code,
  input  logic [1:0] aux_fn,
  output logic       pri_clk,
  output logic       pri_oe,
  output logic       aux_clk,
  output logic       aux_oe
);
  logic   run_v, run_r;
  logic   core_wrap;
  ratio_t core_ratio;
  logic   pri_half, ref_half;

  lvl_sync #(.STAGES(SYNC_STAGES)) u_sync_v (
    .clk(vco_clk), .rst_n(rst_n), .d(run), .q(run_v));

  lvl_sync #(.STAGES(SYNC_STAGES)) u_sync_r (
    .clk(ref_clk), .rst_n(rst_n), .d(run), .q(run_r));

  pdiv_core u_core (
    .clk    (vco_clk),
    .rst_n  (rst_n),
    .active (run_v),
    .code   (div_code),
    .clk_out(pri_clk),
    .wrap   (core_wrap),
    .ratio  (core_ratio)
  );

  half_tog u_pri_half (
    .clk(vco_clk), .rst_n(rst_n), .hold(!run_v), .adv(core_wrap), .q(pri_half));

  half_tog u_ref_half (
    .clk(ref_clk), .rst_n(rst_n), .hold(!run_r), .adv(1'b1), .q(ref_half));

  always_comb begin
    unique case (aux_fn_e'(aux_fn))
      AUX_REF:      aux_clk = ref_clk;
      AUX_REF_HALF: aux_clk = ref_half;
      AUX_LOW:      aux_clk = 1'b0;
      default:      aux_clk = pri_half;
    endcase
  end

  assign pri_oe = run;
  assign aux_oe = run;
endmodule

// File: tb/test_outdiv_top.sv
`timescale 1ns/1ps
module test_outdiv_top;
  logic       vco_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic       run     = 1'b0;
  logic [2:0] div_code = 3'b001;
  logic [1:0] aux_fn   = 2'b10;
  logic       pri_clk, pri_oe, aux_clk, aux_oe;

  int n_chk  = 0;
  int n_fail = 0;

  int    exp_n[$];
  string exp_tag[$];
  int    prev_n = 0;
  event  rise_ev;

  always #2 vco_clk = ~vco_clk;   // 250 MHz
  always #7 ref_clk = ~ref_clk;

  outdiv_top i_outdiv_top (
    .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n), .run(run),
    .div_code(div_code), .aux_fn(aux_fn),
    .pri_clk(pri_clk), .pri_oe(pri_oe), .aux_clk(aux_clk), .aux_oe(aux_oe));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ratio_of(input logic [2:0] c);
    case (c)
      3'b000: return 10;
      3'b001: return 2;
      3'b010: return 8;
      3'b011: return 4;
      3'b100: return 5;
      3'b101: return 7;
      3'b110: return 3;
      default: return 6;
    endcase
  endfunction

  // Monitor: half-cycle samples of the primary clock, one scoreboard entry per period.
  initial begin
    logic s, last_s;
    bit   started;
    int   per, hi, n;
    string tag;
    last_s = 1'b0; started = 0; per = 0; hi = 0;
    forever begin
      @(posedge vco_clk or negedge vco_clk);
      #1;
      s = pri_clk;
      if (!run) started = 0;
      if (s && !last_s) begin
        if (started && exp_n.size() > 0) begin
          n   = exp_n.pop_front();
          tag = exp_tag.pop_front();
          check(per == 2*n, tag, per, 2*n);         // period
          check(hi == n, "R2", hi, n);              // R2 duty
        end
        started = run;
        per = 1; hi = 1;
        -> rise_ev;
      end else if (started) begin
        per++;
        if (s) hi++;
      end
      last_s = s;
    end
  end

  // Driver: applies a code just after a rising primary edge and queues expected periods.
  task automatic seg(input logic [2:0] code, input int periods, input string tag);
    div_code = code;
    if (prev_n != 0) begin
      exp_n.push_back(prev_n);      // R3: period in flight keeps the old ratio
      exp_tag.push_back("R3");
    end
    for (int i = 0; i < periods; i++) begin
      exp_n.push_back(ratio_of(code));
      exp_tag.push_back(tag);
    end
    prev_n = ratio_of(code);
    while (exp_n.size() != 0) @(rise_ev);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic prev;
    // R9: reset state
    #9;
    check(pri_clk == 1'b0, "R9", pri_clk, 0);
    check(pri_oe == 1'b0, "R8", pri_oe, 0);
    check(aux_clk == 1'b0, "R6", aux_clk, 0);
    aux_fn = 2'b11;
    #1;
    check(aux_clk == 1'b0, "R9", aux_clk, 0);
    aux_fn = 2'b10;
    #11 rst_n = 1'b1;
    repeat (4) @(posedge vco_clk);
    #1;
    check(pri_clk == 1'b0, "R8", pri_clk, 0);

    // R1/R2/R3: walk every code
    run = 1'b1;
    prev_n = 0;
    #1;
    check(pri_oe == 1'b1 && aux_oe == 1'b1, "R8", pri_oe, 1);
    seg(3'b001, 4, "R1");
    seg(3'b000, 3, "R1");
    seg(3'b110, 4, "R1");
    seg(3'b101, 3, "R1");
    seg(3'b100, 3, "R1");
    seg(3'b111, 3, "R1");
    seg(3'b010, 3, "R1");
    seg(3'b011, 3, "R1");
    seg(3'b110, 2, "R3");

    // R10: aux function changes while the primary keeps its ratio
    fork
      seg(3'b101, 6, "R10");
      begin
        repeat (5) begin #37; aux_fn = aux_fn + 2'd1; end
      end
    join

    // R4: pass-through of the reference
    aux_fn = 2'b00;
    repeat (4) begin
      @(posedge ref_clk); #2;
      check(aux_clk == 1'b1, "R4", aux_clk, 1);
      @(negedge ref_clk); #2;
      check(aux_clk == 1'b0, "R4", aux_clk, 0);
    end

    // R5: reference divided by two
    aux_fn = 2'b01;
    @(posedge ref_clk); #2;
    prev = aux_clk;
    repeat (5) begin
      @(posedge ref_clk); #2;
      check(aux_clk != prev, "R5", aux_clk, !prev);
      @(negedge ref_clk); #2;
      check(aux_clk != prev, "R5", aux_clk, !prev);
      prev = aux_clk;
    end

    // R6: constant low
    aux_fn = 2'b10;
    repeat (8) begin
      #3;
      check(aux_clk == 1'b0, "R6", aux_clk, 0);
    end

    // R7: primary divided by two
    aux_fn = 2'b11;
    @(rise_ev);
    prev = aux_clk;
    repeat (6) begin
      @(rise_ev);
      check(aux_clk != prev, "R7", aux_clk, !prev);
      prev = aux_clk;
    end

    // R8: power-down mid-period, then a full restart period
    @(rise_ev);
    #5;
    run = 1'b0;
    #1;
    check(pri_oe == 1'b0, "R8", pri_oe, 0);
    check(aux_oe == 1'b0, "R8", aux_oe, 0);
    repeat (5) @(posedge vco_clk);
    repeat (6) begin
      #1;
      check(pri_clk == 1'b0, "R8", pri_clk, 0);
      check(aux_clk == 1'b0, "R8", aux_clk, 0);
      @(negedge vco_clk);
    end
    aux_fn = 2'b01;
    repeat (4) @(posedge ref_clk);
    #2;
    check(aux_clk == 1'b0, "R8", aux_clk, 0);
    prev_n = 0;
    div_code = 3'b100;
    run = 1'b1;
    seg(3'b100, 2, "R8");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule